// File: doc/BRIEF.md
# Instruction Fetch Front End with Stall Stash

This block is the first part of a processor pipeline. It keeps a program counter, reads instruction words from a local synchronous memory and hands each word, with its address and a valid bit, to the decode stage. The counter register drives the memory address directly, so each read gets a whole clock period and there is no logic between the counter and the memory.

The memory read cannot be held back. When decode raises its stall, one word may already be coming out of the memory. A one-entry stash in the second stage keeps that word and hands it to decode, ahead of the memory, as soon as the stall drops. A flush input loads the counter with a new target and throws away every word in flight. Debug inputs can freeze the counter, or let it move forward by exactly one word per step request.

The memory is a synchronous-read array of 32-bit words. Each word holds a code derived from its own address: the word at byte address A reads `32'hC0DE0000 | (A & 32'h3FC)` with the default depth of 256 words.

Top module: `ifetch_front`

## Requirements
- R1: While `rst` is high, `fetch_valid_o` is low. The first word after reset carries address `RESET_ADDR` and is valid at the second rising edge after `rst` falls.
- R2: With no stall, stop or flush, decode receives one new word per cycle, each address 4 above the one before.
- R3: Every valid word's `fetch_insn_o` equals `32'hC0DE0000 | (fetch_addr_o & 32'h3FC)`.
- R4: In a cycle where `dec_stall_i` is high and `flush_i` is low, the outputs keep the same values at the next edge.
- R5: Under any stall pattern, each address reaches decode exactly once and in order. A word is taken in a cycle where `fetch_valid_o` is high and `dec_stall_i` is low.
- R6: After a cycle with `flush_i` high, `fetch_valid_o` is low for two cycles. With no stall, the third cycle shows `redirect_addr_i` as a valid word.
- R7: While `dbg_stop_i` is high and no step is requested, the counter holds. At most two words that are already in flight come out, and after that `fetch_valid_o` stays low.
- R8: While stopped, each one-cycle pulse on `dbg_step_i` lets exactly one more word reach decode. This holds even when the pulse falls during a stall.
- R9: A flush takes priority over a stall and discards a stashed word. The first word delivered after the flush is the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_stall_i | input | 1 | Decode cannot take a word this cycle |
| flush_i | input | 1 | Discard in-flight words and redirect the counter |
| redirect_addr_i | input | 32 | New counter value, used with `flush_i` |
| dbg_stop_i | input | 1 | Freeze the counter |
| dbg_step_i | input | 1 | Request one counter step while stopped |
| fetch_valid_o | output | 1 | Word to decode is valid |
| fetch_addr_o | output | 32 | Address of the word |
| fetch_insn_o | output | 32 | Instruction word |

## Verification
A word issued by the counter at one edge leaves the memory at the next edge and appears at the outputs one edge after that. So the first word after reset, or after a flush, is checked exactly two edges after the counter loads it. A flush clears the outputs at the first edge, and a stall freezes the outputs from the edge that ends the stall cycle. The bench drives its inputs just after each rising edge and samples at the falling edge, with the stall of that same cycle in view. It treats a sample as a taken word only when valid is high and stall is low, and compares it against an expected address that it updates itself, so lost, repeated or reordered words show up on the next word taken.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    localparam int ADDR_W = 32;
    localparam int INSN_W = 32;
    localparam logic [INSN_W-1:0] INSN_TAG = 32'hC0DE_0000;

    // One word travelling toward decode
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
    } fetch_word_t;

    // Memory preload: each word encodes its own byte address
    function automatic logic [INSN_W-1:0] insn_for_index(input int unsigned idx);
        return INSN_TAG | INSN_W'(idx << 2);
    endfunction

endpackage

// File: rtl/ifetch_pc.sv
module ifetch_pc
    import ifetch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] redir_i,
    input  logic              stop_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              issue_o
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic              step_pend_q;
    logic              step_req;
    logic              run;
    logic              adv;

    assign step_req = step_i | step_pend_q;
    assign run      = !stop_i || step_req;
    assign adv      = !stall_i && run;

    always_comb begin
        pc_d = pc_q;
        if (flush_i) begin
            pc_d = redir_i;
        end else if (adv) begin
            pc_d = pc_q + ADDR_W'(4);    // the only increment
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q        <= RESET_ADDR;
            step_pend_q <= 1'b0;
        end else begin
            pc_q        <= pc_d;
            step_pend_q <= stop_i && !flush_i && step_req && !adv;
        end
    end

    assign pc_o    = pc_q;
    assign issue_o = adv && !flush_i && !rst;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> pc_q == RESET_ADDR);                                        // R1
    AST_PC_STEP4: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> pc_q == $past(pc_q) + ADDR_W'(4));                      // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !step_req && !flush_i) |=> $stable(pc_q));               // R7
    AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> pc_q == $past(redir_i));                                // R6

endmodule

// File: rtl/ifetch_imem.sv
module ifetch_imem
    import ifetch_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int IDX_W = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_issue_i,
    output fetch_word_t       word_o
);

    logic [INSN_W-1:0] mem [MEM_WORDS];
    logic [INSN_W-1:0] rdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i] = insn_for_index(i);
        end
    end

    // Read every cycle: the read port has no enable and no stall
    always_ff @(posedge clk) begin
        rdata_q <= mem[rd_idx_i];
        addr_q  <= rd_addr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= rd_issue_i;
    end

    assign word_o = '{vld: vld_q, addr: addr_q, insn: rdata_q};

endmodule

// File: rtl/ifetch_stash.sv
module ifetch_stash
    import ifetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stall_i,
    input  logic        flush_i,
    input  fetch_word_t mem_word_i,
    output fetch_word_t out_o
);

    fetch_word_t stash_q;
    fetch_word_t out_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            stash_q.vld <= 1'b0;
            out_q.vld   <= 1'b0;
        end else if (stall_i) begin
            if (mem_word_i.vld && !stash_q.vld) begin
                stash_q <= mem_word_i;
            end
        end else if (stash_q.vld) begin
            out_q       <= stash_q;
            stash_q.vld <= 1'b0;
        end else begin
            out_q <= mem_word_i;
        end
    end

    assign out_o = out_q;

    AST_STASH_EXCL: assert property (@(posedge clk) disable iff (rst)
        stash_q.vld |-> !mem_word_i.vld);                                   // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !flush_i) |=> $stable(out_q));                          // R4
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !out_q.vld && !stash_q.vld);                            // R9

endmodule

// File: rtl/ifetch_front.sv
module ifetch_front
    import ifetch_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0000_0100,
    parameter int          MEM_WORDS  = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dec_stall_i,
    input  logic        flush_i,
    input  logic [31:0] redirect_addr_i,
    input  logic        dbg_stop_i,
    input  logic        dbg_step_i,
    output logic        fetch_valid_o,
    output logic [31:0] fetch_addr_o,
    output logic [31:0] fetch_insn_o
);

    localparam int IDX_W = $clog2(MEM_WORDS);

    logic [ADDR_W-1:0] pc;
    logic              issue;
    fetch_word_t       mem_word;
    fetch_word_t       out_word;

    ifetch_pc #(.RESET_ADDR(RESET_ADDR)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .stall_i (dec_stall_i),
        .flush_i (flush_i),
        .redir_i (redirect_addr_i),
        .stop_i  (dbg_stop_i),
        .step_i  (dbg_step_i),
        .pc_o    (pc),
        .issue_o (issue)
    );

    ifetch_imem #(.MEM_WORDS(MEM_WORDS)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .rd_idx_i   (pc[IDX_W+1:2]),
        .rd_addr_i  (pc),
        .rd_issue_i (issue),
        .word_o     (mem_word)
    );

    ifetch_stash u_stage2 (
        .clk        (clk),
        .rst        (rst),
        .stall_i    (dec_stall_i),
        .flush_i    (flush_i),
        .mem_word_i (mem_word),
        .out_o      (out_word)
    );

    assign fetch_valid_o = out_word.vld;
    assign fetch_addr_o  = out_word.addr;
    assign fetch_insn_o  = out_word.insn;

    AST_VALID_IN_RESET: assert property (@(posedge clk)
        rst |=> !fetch_valid_o);                                            // R1

endmodule

// File: tb/ifetch_front_test.sv
module ifetch_front_test;

    localparam logic [31:0] RST_A = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_stall_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] redirect_addr_i = '0;
    logic        dbg_stop_i = 1'b0;
    logic        dbg_step_i = 1'b0;
    logic        fetch_valid_o;
    logic [31:0] fetch_addr_o;
    logic [31:0] fetch_insn_o;

    int n_checks = 0;
    int n_fail   = 0;
    int accepts  = 0;
    logic [31:0] exp_addr = RST_A;

    always #5 clk = ~clk;

    ifetch_front #(.RESET_ADDR(RST_A)) uut (.*);

    function automatic logic [31:0] exp_insn(input logic [31:0] a);
        return 32'hC0DE_0000 | (a & 32'h3FC);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: sample at falling edge, with this cycle's stall in view
    always @(negedge clk) begin
        if (!rst) begin
            if (flush_i) begin
                exp_addr = redirect_addr_i;
            end else if (fetch_valid_o && !dec_stall_i) begin
                chk(fetch_addr_o == exp_addr, "R5 order", fetch_addr_o, exp_addr);
                chk(fetch_insn_o == exp_insn(fetch_addr_o), "R3 data", fetch_insn_o, exp_insn(fetch_addr_o));
                exp_addr = exp_addr + 32'd4;
                accepts++;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int a0;
        logic [31:0] held_a;
        logic [31:0] redir;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!fetch_valid_o, "R1 valid in reset", 32'(fetch_valid_o), 0);
        tick(); rst = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(fetch_valid_o && fetch_addr_o == RST_A, "R1 first word", fetch_addr_o, RST_A);

        // R2: throughput
        a0 = accepts;
        repeat (8) @(negedge clk);
        chk(accepts - a0 == 8, "R2 one per cycle", 32'(accepts - a0), 8);

        // R4: stall holds outputs
        tick(); dec_stall_i = 1'b1;
        @(negedge clk); held_a = fetch_addr_o;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(fetch_addr_o == held_a && fetch_valid_o, "R4 hold", fetch_addr_o, held_a);
        end
        tick(); dec_stall_i = 1'b0;
        repeat (4) tick();

        // R6: flush latency
        tick(); flush_i = 1'b1; redirect_addr_i = 32'h0000_0200;
        tick(); flush_i = 1'b0;
        @(negedge clk); chk(!fetch_valid_o, "R6 cleared", 32'(fetch_valid_o), 0);
        @(negedge clk); chk(!fetch_valid_o, "R6 bubble", 32'(fetch_valid_o), 0);
        @(negedge clk); chk(fetch_valid_o && fetch_addr_o == 32'h200, "R6 target", fetch_addr_o, 32'h200);
        repeat (3) tick();

        // R9: flush while stalled with stash full
        dec_stall_i = 1'b1;
        repeat (3) tick();
        flush_i = 1'b1; redirect_addr_i = 32'h0000_0040;
        tick(); flush_i = 1'b0; dec_stall_i = 1'b0;
        @(negedge clk); chk(!fetch_valid_o, "R9 cleared", 32'(fetch_valid_o), 0);
        @(negedge clk);
        @(negedge clk); chk(fetch_valid_o && fetch_addr_o == 32'h40, "R9 target", fetch_addr_o, 32'h40);
        repeat (3) tick();

        // R7: stop
        a0 = accepts;
        dbg_stop_i = 1'b1;
        repeat (6) tick();
        chk(accepts - a0 <= 2, "R7 drain", 32'(accepts - a0), 2);
        a0 = accepts;
        repeat (6) tick();
        chk(accepts == a0 && !fetch_valid_o, "R7 frozen", 32'(accepts - a0), 0);

        // R8: single steps, one of them during a stall
        a0 = accepts;
        dbg_step_i = 1'b1; tick(); dbg_step_i = 1'b0;
        repeat (5) tick();
        chk(accepts - a0 == 1, "R8 step", 32'(accepts - a0), 1);
        a0 = accepts;
        dec_stall_i = 1'b1; dbg_step_i = 1'b1; tick();
        dbg_step_i = 1'b0; dec_stall_i = 1'b0;
        repeat (5) tick();
        chk(accepts - a0 == 1, "R8 step in stall", 32'(accepts - a0), 1);
        dbg_stop_i = 1'b0;

        // Random phase: R5 under random stalls and flushes
        void'($urandom(32'd1234));
        a0 = accepts;
        for (int c = 0; c < 3000; c++) begin
            dec_stall_i = ($urandom % 100) < 35;
            flush_i = ($urandom % 64) == 0;
            redir = ($urandom % 1024) & 32'hFFC;
            redirect_addr_i = redir;
            tick();
        end
        dec_stall_i = 1'b0; flush_i = 1'b0;
        repeat (4) tick();
        chk(accepts - a0 > 1000, "R5 progress", 32'(accepts - a0), 1000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule